// File: doc/BRIEF.md
# Cache Block Zero Sequencer

This block clears one cache-sized block of memory by issuing a run of word-wide zero stores. A one-cycle start request carries a base effective address. From the following cycle the block drives a 32-bit write port with a valid/ready handshake, one word per accepted transfer. The address begins at the base and rises by four bytes with each accepted store.

The length of the run is set by the line-size parameter. A 32-byte line gives eight stores and a 64-byte line gives sixteen. One cycle after the final store is accepted, a done pulse marks the end of the run. A busy flag covers the whole run, and a start request that arrives during a run is dropped. The block does not look up cache tags, allocate lines or take part in coherence. It only sequences the stores.

Top module: `blkzero_seq`

## Requirements
- R1: After reset, busy_o, wr_valid_o and done_o are low.
- R2: A start_i pulse while idle makes wr_valid_o and busy_o high on the next cycle, with wr_addr_o equal to base_i exactly as given. Low address bits are not masked.
- R3: wr_data_o is 32'h0000_0000 for every store.
- R4: Each accepted store (wr_valid_o and wr_ready_i both high at a clock edge) advances wr_addr_o by 4, modulo 2^32, for the next store.
- R5: With LINE_BYTES=32 a run is exactly 8 accepted stores, and the last one is at base+0x1C.
- R6: With LINE_BYTES=64 a run is exactly 16 accepted stores, and the last one is at base+0x3C.
- R7: While wr_valid_o is high and wr_ready_i is low, wr_addr_o and wr_data_o hold and wr_valid_o stays high.
- R8: A start_i pulse while busy_o is high has no effect: the address sequence, the store count and the base of the current run are unchanged.
- R9: done_o is high for exactly one cycle, the cycle after the last store is accepted. In that same cycle busy_o and wr_valid_o are low.
- R10: busy_o equals wr_valid_o. It rises only in the cycle after an accepted start and stays high until the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, one cycle |
| base_i | input | ADDR_W | Base effective address, sampled with start_i |
| busy_o | output | 1 | A run is active |
| wr_valid_o | output | 1 | A store is offered on the write port |
| wr_addr_o | output | ADDR_W | Store address |
| wr_data_o | output | DATA_W | Store data, always zero |
| wr_ready_i | input | 1 | Write port accepts the offered store |
| done_o | output | 1 | One-cycle pulse after the last accepted store |

## Verification
An accepted start shows on the port one clock edge later as valid and the base address. Each accepted store moves the address one edge later. done_o and the falling busy_o appear one edge after the final acceptance. The bench keeps a cycle model that is updated on rising edges from the inputs alone. It compares the outputs on falling edges, so every expected value is read exactly one register stage after the input that caused it. Two instances, one per line size, share the same start, base and a ready line that is random, always high or sparse. A store counter checks each done pulse against the run length and the final offset.

// File: rtl/blkzero_pkg.sv
package blkzero_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;
endpackage

// File: rtl/blkzero_ctrl.sv
module blkzero_ctrl
  import blkzero_pkg::*;
#(
  parameter int NUM_WORDS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic ready_i,
  output logic load_o,
  output logic step_o,
  output logic active_o,
  output logic done_o
);
  localparam int CNT_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_WORDS - 1);

  run_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_w;
  logic             done_q;

  assign load_o   = (state_q == RUN_IDLE) && start_i;
  assign step_o   = (state_q == RUN_ACTIVE) && ready_i;
  assign last_w   = (cnt_q == LAST_IDX);
  assign active_o = (state_q == RUN_ACTIVE);
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RUN_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= step_o && last_w;
      if (load_o) begin
        state_q <= RUN_ACTIVE;
        cnt_q   <= '0;
      end else if (step_o) begin
        if (last_w) begin
          state_q <= RUN_IDLE;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/blkzero_addr.sv
module blkzero_addr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
    end else if (step_i) begin
      addr_q <= addr_q + STEP_V;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/blkzero_seq.sv
module blkzero_seq #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              done_o
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int NUM_WORDS  = LINE_BYTES / WORD_BYTES;

  logic load_w;
  logic step_w;
  logic active_w;

  blkzero_ctrl #(
    .NUM_WORDS(NUM_WORDS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ready_i (wr_ready_i),
    .load_o  (load_w),
    .step_o  (step_w),
    .active_o(active_w),
    .done_o  (done_o)
  );

  blkzero_addr #(
    .ADDR_W(ADDR_W),
    .STEP  (WORD_BYTES)
  ) u_addr (
    .clk   (clk),
    .rst   (rst),
    .load_i(load_w),
    .step_i(step_w),
    .base_i(base_i),
    .addr_o(wr_addr_o)
  );

  assign busy_o     = active_w;
  assign wr_valid_o = active_w;
  assign wr_data_o  = '0;
endmodule

// File: rtl/blkzero_chk.sv
module blkzero_chk #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              busy_o,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              wr_ready_i,
  input logic              done_o
);
  // R7
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)));

  // R2
  load_base_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (wr_valid_o && wr_addr_o == $past(base_i)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && wr_ready_i) |=>
      (!wr_valid_o || wr_addr_o == $past(wr_addr_o) + ADDR_W'(STEP)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9
  done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(wr_valid_o && wr_ready_i) && !busy_o));

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind blkzero_seq blkzero_chk #(
  .ADDR_W(ADDR_W),
  .STEP  (DATA_W / 8)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .base_i    (base_i),
  .busy_o    (busy_o),
  .wr_valid_o(wr_valid_o),
  .wr_addr_o (wr_addr_o),
  .wr_ready_i(wr_ready_i),
  .done_o    (done_o)
);

// File: tb/blkzero_seq_tb_top.sv
module blkzero_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic        ready = 1'b0;
  int          ready_mode = 0;

  logic        busy_v  [2];
  logic        valid_v [2];
  logic        done_v  [2];
  logic [31:0] addr_v  [2];
  logic [31:0] data_v  [2];

  int          vectors = 0;
  int          fails = 0;

  localparam int LW [2] = '{8, 16};

  // bench model
  logic        m_busy [2];
  logic        m_done [2];
  logic [31:0] m_base [2];
  int          m_idx  [2];
  int          acc_cnt [2];
  logic [31:0] last_addr [2];

  always #10 clk = ~clk;

  blkzero_seq #(.LINE_BYTES(32)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .base_i(base),
    .busy_o(busy_v[0]), .wr_valid_o(valid_v[0]), .wr_addr_o(addr_v[0]),
    .wr_data_o(data_v[0]), .wr_ready_i(ready), .done_o(done_v[0]));

  blkzero_seq #(.LINE_BYTES(64)) dut64_i (
    .clk(clk), .rst(rst), .start_i(start), .base_i(base),
    .busy_o(busy_v[1]), .wr_valid_o(valid_v[1]), .wr_addr_o(addr_v[1]),
    .wr_data_o(data_v[1]), .wr_ready_i(ready), .done_o(done_v[1]));

  function automatic logic [31:0] exp_addr(int k);
    return m_base[k] + 32'(m_idx[k] * 4);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_busy[k] <= 1'b0; m_done[k] <= 1'b0; m_idx[k] <= 0; m_base[k] <= '0;
      end else begin
        m_done[k] <= 1'b0;
        if (!m_busy[k] && start) begin
          m_busy[k] <= 1'b1; m_base[k] <= base; m_idx[k] <= 0;
        end else if (m_busy[k] && ready) begin
          if (m_idx[k] == LW[k] - 1) begin
            m_busy[k] <= 1'b0; m_done[k] <= 1'b1;
          end else begin
            m_idx[k] <= m_idx[k] + 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 2; k++) begin
        check(valid_v[k] == m_busy[k], "R10 valid", 32'(valid_v[k]), 32'(m_busy[k]));
        check(busy_v[k] == m_busy[k], "R10 busy", 32'(busy_v[k]), 32'(m_busy[k]));
        check(done_v[k] == m_done[k], "R9 done", 32'(done_v[k]), 32'(m_done[k]));
        if (m_busy[k]) begin
          check(addr_v[k] == exp_addr(k), "R4 addr", addr_v[k], exp_addr(k));
          check(data_v[k] == 32'h0, "R3 data", data_v[k], 32'h0);
        end
        if (done_v[k]) begin
          if (k == 0) begin
            check(acc_cnt[k] == 8, "R5 count", 32'(acc_cnt[k]), 32'd8);
            check(last_addr[k] == m_base[k] + 32'h1C, "R5 last", last_addr[k],
                  m_base[k] + 32'h1C);
          end else begin
            check(acc_cnt[k] == 16, "R6 count", 32'(acc_cnt[k]), 32'd16);
            check(last_addr[k] == m_base[k] + 32'h3C, "R6 last", last_addr[k],
                  m_base[k] + 32'h3C);
          end
          acc_cnt[k] = 0;
        end
      end
    end
    case (ready_mode)
      0: ready = 1'b1;
      1: ready = ($urandom % 2) == 0;
      default: ready = ($urandom % 5) == 0;
    endcase
    for (int k = 0; k < 2; k++) begin
      if (rst) acc_cnt[k] = 0;
      else if (valid_v[k] && ready) begin
        acc_cnt[k] = acc_cnt[k] + 1;
        last_addr[k] = addr_v[k];
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    for (int k = 0; k < 2; k++) begin
      check(!busy_v[k] && !valid_v[k] && !done_v[k], "R1 reset",
            {29'd0, busy_v[k], valid_v[k], done_v[k]}, 32'h0);
    end
    for (int b = 0; b < 30; b++) begin
      logic [31:0] nb;
      nb = $urandom;
      if (b == 0) nb = 32'h0000_0000;
      if (b == 1) nb = 32'h0000_1001;   // R2 unaligned base kept
      if (b == 2) nb = 32'hFFFF_FFE0;   // R4 wrap
      ready_mode = b % 3;
      @(negedge clk);
      start = 1'b1; base = nb;
      @(negedge clk);
      start = 1'b0;
      check(m_busy[0] && addr_v[0] == nb, "R2 base", addr_v[0], nb);
      if (b % 4 == 1) begin
        // R8 start while busy is dropped
        @(negedge clk);
        start = 1'b1; base = ~nb;
        @(negedge clk);
        start = 1'b0;
      end
      while (m_busy[0] || m_busy[1] || m_done[0] || m_done[1]) @(negedge clk);
      @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule